// File: doc/BRIEF.md
# Tiled Surface Address Generator

A copy datapath that walks a tiled surface needs a handful of derived values before it can start. The inputs are a surface description (tile mode, width, height, bytes per pixel, a 40-bit base address) and a start coordinate (x, y, z). This block computes from them the byte address of the starting pixel, the pitch between tile rows, a y-tile register word and a yz tile-size word.

The surface is split into tiles on three levels. A tile is 2^Tp bytes wide, 2^Th rows tall and 2^Td slices deep. The block counts how many tiles span the surface horizontally and vertically, with partial tiles rounded up. It splits the start coordinate into a tile index and an offset within the tile. The address is then the base plus the offset of the whole tile plus the offset inside it. The two large products in the tile index are formed by a shift-and-add multiplier that runs over several cycles. A start pulse begins a job and a single-cycle done pulse ends it. Linear surfaces do not use this block.

Top module: `tile_addr_gen`

## Requirements
- R1: While reset is low, and after it is released, `done` is 0 and every result output is 0 until the first job ends.
- R2: Tile mode decode: Tp = 6 + mode[3:0], Th = 2 + mode[7:4], Td = mode[11:8]. All other results follow from these shifts.
- R3: `pitch` = (nTx − 1) << (Tp+Th+Td), taken modulo 2^32, where nTx = ceil(width·bpp / 2^Tp).
- R4: `ytile` = (2^Th << 12) | (2^Th − (y mod 2^Th)).
- R5: `yz_size` = (2^Th >> 2) << Td.
- R6: `addr_lo` = (base_lo + inner + (((z>>Td)·nTy + (y>>Th))·nTx + ((x·bpp)>>Tp) << (Tp+Th+Td))) mod 2^32. Here nTy = ceil(height / 2^Th) and inner = ((z mod 2^Td) << (Tp+Th)) + ((y mod 2^Th) << Tp) + ((x·bpp) mod 2^Tp).
- R7: `addr_hi` holds base_hi in bits [7:0] and the carry out of the R6 addition in bit 16. Bits [15:8] are 0.
- R8: `done` is high for exactly one cycle per job. The results change only in the cycle in which `done` is high.
- R9: A `start` that arrives while a job is running has no effect. That job's results are unchanged and no extra `done` follows.
- R10: `done` arrives no more than 64 cycles after the accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a job; the surface inputs are captured on this cycle |
| tile_mode | input | 12 | Tile shift fields (see R2) |
| width | input | 19 | Surface width in pixels |
| height | input | 13 | Surface height in rows |
| x_off | input | 19 | Start x in pixels |
| y_off | input | 13 | Start row |
| z_off | input | 12 | Start slice |
| bpp | input | 5 | Bytes per pixel |
| base_lo | input | 32 | Base address bits [31:0] |
| base_hi | input | 8 | Base address bits [39:32] |
| done | output | 1 | One-cycle pulse when the results are updated |
| addr_lo | output | 32 | Start pixel address, low word |
| addr_hi | output | 17 | base_hi in [7:0], carry in [16] |
| pitch | output | 32 | Tiled pitch |
| ytile | output | 32 | Y-tile register word |
| yz_size | output | 32 | YZ tile-size word |

## Verification
Most internal faults show up at `addr_lo` in the cycle `done` rises. Examples are a wrongly decoded shift field, a dropped partial-tile round-up, or a multiplier step that skips a partial product. The bench sweeps every tile shift combination it uses against several coordinates, so such a fault produces a mismatch within the first few jobs. A wrong carry appears only when the base sits near the top of the 32-bit range, and the sweep includes such bases. A state machine that leaks a second `start` changes the results of the running job, or raises an extra `done`, within one job length.

// File: rtl/tile_addr_gen.sv
module tile_addr_gen (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [11:0] tile_mode,
  input  logic [18:0] width,
  input  logic [12:0] height,
  input  logic [18:0] x_off,
  input  logic [12:0] y_off,
  input  logic [11:0] z_off,
  input  logic [4:0]  bpp,
  input  logic [31:0] base_lo,
  input  logic [7:0]  base_hi,
  output logic        done,
  output logic [31:0] addr_lo,
  output logic [16:0] addr_hi,
  output logic [31:0] pitch,
  output logic [31:0] ytile,
  output logic [31:0] yz_size
);
  localparam int DW = 32;
  localparam int LAT_MAX = 64;

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_MUL1, S_MUL2} st_t;
  st_t st;

  logic [11:0] tm_r;
  logic [18:0] w_r, x_r;
  logic [12:0] h_r, y_r;
  logic [11:0] z_r;
  logic [4:0]  bpp_r;
  logic [31:0] blo_r;
  logic [7:0]  bhi_r;
  logic [DW-1:0] ma, mb, acc;

  logic [4:0] tp, th;
  logic [3:0] td;
  logic [5:0] sh;
  assign tp = 5'd6 + {1'b0, tm_r[3:0]};
  assign th = 5'd2 + {1'b0, tm_r[7:4]};
  assign td = tm_r[11:8];
  assign sh = 6'(tp) + 6'(th) + 6'(td);

  logic [DW-1:0] xb, wb, pmask, hmask, dmask;
  assign xb    = DW'(x_r) * DW'(bpp_r);
  assign wb    = DW'(w_r) * DW'(bpp_r);
  assign pmask = (DW'(1) << tp) - DW'(1);
  assign hmask = (DW'(1) << th) - DW'(1);
  assign dmask = (DW'(1) << td) - DW'(1);

  logic [DW-1:0] txo, tx, tyo, ty, tzo, tz, ntx, nty, inner, toff;
  assign txo   = xb & pmask;
  assign tx    = xb >> tp;
  assign tyo   = DW'(y_r) & hmask;
  assign ty    = DW'(y_r) >> th;
  assign tzo   = DW'(z_r) & dmask;
  assign tz    = DW'(z_r) >> td;
  assign ntx   = (wb + pmask) >> tp;
  assign nty   = (DW'(h_r) + hmask) >> th;
  assign inner = ((tzo << tp) << th) + (tyo << tp) + txo;
  assign toff  = (acc << sh) + inner;

  logic [DW:0] sum;
  assign sum = {1'b0, blo_r} + {1'b0, toff};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      done <= 1'b0;
      addr_lo <= '0; addr_hi <= '0; pitch <= '0; ytile <= '0; yz_size <= '0;
      tm_r <= '0; w_r <= '0; h_r <= '0; x_r <= '0; y_r <= '0; z_r <= '0;
      bpp_r <= '0; blo_r <= '0; bhi_r <= '0;
      ma <= '0; mb <= '0; acc <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          tm_r <= tile_mode; w_r <= width; h_r <= height;
          x_r <= x_off; y_r <= y_off; z_r <= z_off;
          bpp_r <= bpp; blo_r <= base_lo; bhi_r <= base_hi;
          st <= S_SETUP;
        end
        S_SETUP: begin
          ma <= tz; mb <= nty; acc <= ty;
          st <= S_MUL1;
        end
        S_MUL1, S_MUL2: begin
          if (mb != '0) begin
            if (mb[0]) acc <= acc + ma;
            ma <= ma << 1;
            mb <= mb >> 1;
          end else if (st == S_MUL1) begin
            ma <= acc; mb <= ntx; acc <= tx;
            st <= S_MUL2;
          end else begin
            addr_lo <= sum[DW-1:0];
            addr_hi <= {sum[DW], 8'd0, bhi_r};
            pitch   <= (ntx - DW'(1)) << sh;
            ytile   <= ((DW'(1) << th) << 12) | ((DW'(1) << th) - tyo);
            yz_size <= ((DW'(1) << th) >> 2) << td;
            done    <= 1'b1;
            st      <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [6:0] lat;
  always_ff @(posedge clk) begin
    if (!rst_n || st == S_IDLE) lat <= '0;
    else if (lat != 7'h7f) lat <= lat + 7'd1;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(addr_lo) && $stable(pitch) && $stable(ytile) && $stable(addr_hi))); // R8
  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && start) |=> $stable(tm_r) && $stable(x_r)); // R9
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) lat < 7'(LAT_MAX)); // R10
  AST_HI_GAP: assert property (@(posedge clk) disable iff (!rst_n) done |-> addr_hi[7:0] == bhi_r); // R7
endmodule

// File: tb/sim_tile_addr_gen.sv
`timescale 1ns/1ps
module sim_tile_addr_gen;
  logic clk = 0, rst_n = 0, start = 0;
  logic [11:0] tile_mode = 0;
  logic [18:0] width = 0, x_off = 0;
  logic [12:0] height = 0, y_off = 0;
  logic [11:0] z_off = 0;
  logic [4:0]  bpp = 0;
  logic [31:0] base_lo = 0;
  logic [7:0]  base_hi = 0;
  logic done;
  logic [31:0] addr_lo, pitch, ytile, yz_size;
  logic [16:0] addr_hi;
  int checks = 0, fails = 0;
  bit wd_hit = 0;

  always #2.5 clk = ~clk;

  tile_addr_gen u0 (.clk, .rst_n, .start, .tile_mode, .width, .height, .x_off, .y_off,
    .z_off, .bpp, .base_lo, .base_hi, .done, .addr_lo, .addr_hi, .pitch, .ytile, .yz_size);

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [31:0] e_lo, e_pitch, e_yt, e_yz;
  logic [16:0] e_hi;

  task automatic model();
    longint unsigned tp, th, td, sh, xb, wb, ntx, nty, t, inner, s;
    tp = 6 + tile_mode[3:0]; th = 2 + tile_mode[7:4]; td = tile_mode[11:8];
    sh = tp + th + td;
    xb = x_off * bpp; wb = width * bpp;
    ntx = (wb + (64'd1 << tp) - 1) >> tp;
    nty = (height + (64'd1 << th) - 1) >> th;
    t = (((z_off >> td) * nty + (y_off >> th)) * ntx + (xb >> tp)) & 64'hffffffff;
    inner = ((z_off & ((64'd1 << td) - 1)) << (tp + th)) + ((y_off & ((64'd1 << th) - 1)) << tp)
            + (xb & ((64'd1 << tp) - 1));
    s = base_lo + (((t << sh) + inner) & 64'hffffffff);
    e_lo = s[31:0];
    e_hi = {s[32], 8'd0, base_hi};
    e_pitch = 32'((ntx - 1) << sh);
    e_yt = 32'(((64'd1 << th) << 12) | ((64'd1 << th) - (y_off & ((64'd1 << th) - 1))));
    e_yz = 32'(((64'd1 << th) >> 2) << td);
  endtask

  task automatic run_job(output int lat);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    lat = 1;
    while (!done && lat < 200) begin @(negedge clk); lat++; end
  endtask

  task automatic compare_all();
    chk("R6 addr_lo", addr_lo, e_lo);
    chk("R7 addr_hi", addr_hi, e_hi);
    chk("R3 pitch", pitch, e_pitch);
    chk("R4 ytile", ytile, e_yt);
    chk("R5 yz_size", yz_size, e_yz);
  endtask

  initial begin
    #200000;
    wd_hit = 1;
  end

  initial begin : main
    int lat;
    repeat (3) @(negedge clk);
    chk("R1 done in reset", done, 0);
    chk("R1 addr_lo in reset", addr_lo, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 done after reset", done, 0);
    chk("R1 pitch after reset", pitch, 0);
    chk("R1 ytile after reset", ytile, 0);
    // R2 sweep of shift fields, bpp and coordinates
    for (int a = 0; a < 3 && !wd_hit; a++)
      for (int b = 0; b < 3; b++)
        for (int c = 0; c < 3; c++)
          for (int p = 0; p < 3; p++)
            for (int k = 0; k < 3; k++) begin
              tile_mode = {4'(c), 4'(b), 4'(a)};
              bpp = 5'(1 << p);
              width = 19'(300 + 97 * k); height = 13'(50 + 33 * k);
              x_off = 19'(17 + 61 * k + a); y_off = 13'(3 + 11 * k + b); z_off = 12'(1 + 2 * k + c);
              base_lo = (k == 2) ? 32'hffff_ff00 - 32'(a * 4096) : 32'h1234_5000 + 32'(k);
              base_hi = 8'(8'h40 + k + a);
              model();
              run_job(lat);
              chk("R8 done seen", done, 1);
              chk("R10 latency", lat <= 64, 1);
              compare_all();
              @(negedge clk);
              chk("R8 done one cycle", done, 0);
            end
    // R7 carry case forced
    tile_mode = 12'h000; bpp = 5'd4; width = 19'd1000; height = 13'd100;
    x_off = 19'd200; y_off = 13'd40; z_off = 12'd0; base_lo = 32'hffff_fff0; base_hi = 8'h7e;
    model(); run_job(lat); chk("R7 carry set", addr_hi[16], e_hi[16]); compare_all();
    // R9 start while busy
    tile_mode = 12'h121; bpp = 5'd2; width = 19'd4000; height = 13'd900;
    x_off = 19'd777; y_off = 13'd333; z_off = 12'd5; base_lo = 32'h0800_0000; base_hi = 8'h01;
    model();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    @(negedge clk);
    tile_mode = 12'h000; x_off = 19'd1; y_off = 13'd1; base_lo = 32'h0; start = 1;
    @(negedge clk); start = 0;
    lat = 3;
    while (!done && lat < 200) begin @(negedge clk); lat++; end
    chk("R9 busy start done", done, 1);
    compare_all();
    begin
      int extra = 0;
      for (int i = 0; i < 80; i++) begin @(negedge clk); if (done) extra++; end
      chk("R9 no extra done", extra, 0);
      chk("R8 outputs held", addr_lo, e_lo);
    end
    if (wd_hit) begin fails++; checks++; $display("FAIL watchdog R10 actual=timeout expected=finish"); end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  always @(posedge wd_hit) begin
    fails++; checks++;
    $display("FAIL watchdog R10 actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule